// File: doc/BRIEF.md
# Split-Space Instruction Fetch Unit

This block is the fetch and branch-control stage of a small core. The core can run code from two places. One is a 512-word local register RAM. The other is a wide shared memory that the core may read only when an outside arbiter grants it a slot. The block holds a 17-bit word program counter, and the address alone picks the source: low addresses read the register RAM and all others read shared memory. Each instruction goes to a decode stub together with its address.

A shared-memory read returns a 128-bit line of four words. In basic mode the block keeps only the one word it needs, so every shared-memory instruction costs a slot. In enhanced mode the block keeps the whole line in a single tagged latch. Later words in the same aligned block are then issued without another slot. A write to shared memory that lands on the latched line drops that line.

The decoder answers each issued instruction with a branch request. The request can be a far jump, a far call or a return. A far call stores the return address and the Z and C flags in a fixed register of the register RAM. A return reads that register and can give the flags back to the core.

Top module: `split_fetch`

## Requirements
- R1: After a synchronous reset, `instr_valid` is 0, `pc` is 0 and `sh_req` is 0, and the line latch holds nothing.
- R2: An address below 0x200 reads register RAM word `pc[8:0]` and never raises `sh_req`. An address at or above 0x200 raises `sh_req` with `sh_qaddr = pc[16:2]` and takes word `pc[1:0]`, where word k is `rdata[32*k+31:32*k]`. `loc_we` writes `loc_wdata` into register RAM word `loc_waddr` at the clock edge.
- R3: `instr_valid` is high for exactly one cycle per instruction and is never high in two consecutive cycles. A register-RAM instruction issues in the cycle after its fetch cycle.
- R4: `br_valid` counts only in an issue cycle. There, `br_op` 2'b00 or 2'b11 is a far jump to `{br_dst[7:0], br_src}`, and `br_dst[8]` is ignored. Without a branch the next address is `pc + 1`, wrapping at 17 bits. A far jump writes nothing.
- R5: While a shared fetch is waiting, `sh_req` stays high and nothing issues. The instruction issues in the cycle after the first cycle that has `slot_grant` high. `pc` changes only after an issue cycle.
- R6: With `quad_mode` = 0, every shared-memory instruction needs its own granted slot.
- R7: With `quad_mode` = 1, a granted read loads the line latch. A later fetch inside the same aligned four-word block issues from the latch without `sh_req` and without waiting, in the cycle after its fetch cycle.
- R8: A `snoop_wr` whose `snoop_qaddr` equals the latched block address invalidates the latch. If that write falls in the same cycle as the grant that fills the latch with that block, the fetched word still issues, but the latch is left invalid.
- R9: A far call (`br_op` 2'b01) jumps to `{br_dst[7:0], br_src}` and writes register 0x1EF with bits [16:0] = `pc + 1`, bit 17 = `flag_c`, bit 18 = `flag_z` and the other bits 0. This write wins over a `loc_we` to the same word in the same cycle.
- R10: A return (`br_op` 2'b10) jumps to bits [16:0] of register 0x1EF. In that issue cycle `z_load` = `ret_wz`, `c_load` = `ret_wc`, `z_rest` = bit 18 and `c_rest` = bit 17. `z_load` and `c_load` are 0 at all other times.
- R11: Any cycle with `quad_mode` = 0 empties the line latch, so the first shared fetch after a return to enhanced mode needs a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_mode | input | 1 | 1 = keep the fetched four-word line, 0 = one word per slot |
| slot_grant | input | 1 | Shared-memory slot for this core in this cycle |
| rdata | input | 128 | Shared-memory line for `sh_qaddr`, valid with `slot_grant` |
| sh_req | output | 1 | A shared fetch is waiting for a slot |
| sh_qaddr | output | 15 | Line address of the pending shared fetch |
| snoop_wr | input | 1 | A shared-memory write happens this cycle |
| snoop_qaddr | input | 15 | Line address of that write |
| loc_we | input | 1 | Register RAM write enable |
| loc_waddr | input | 9 | Register RAM write address |
| loc_wdata | input | 32 | Register RAM write data |
| br_valid | input | 1 | Decoder branch request for the issued instruction |
| br_op | input | 2 | 00/11 jump, 01 call, 10 return |
| br_dst | input | 9 | Destination field, its low 8 bits are target bits [16:9] |
| br_src | input | 9 | Source field, target bits [8:0] |
| flag_z | input | 1 | Current Z flag, saved by a call |
| flag_c | input | 1 | Current C flag, saved by a call |
| ret_wz | input | 1 | Return should restore Z |
| ret_wc | input | 1 | Return should restore C |
| instr_valid | output | 1 | An instruction is issued this cycle |
| instr | output | 32 | Issued instruction word |
| pc | output | 17 | Address of the instruction being fetched or issued |
| z_load | output | 1 | Load Z from `z_rest` |
| c_load | output | 1 | Load C from `c_rest` |
| z_rest | output | 1 | Saved Z value |
| c_rest | output | 1 | Saved C value |

## Verification
A latch fill and a snoop invalidation can fall in the same cycle. This happens when the slot that fills the line arrives together with a shared-memory write to that same line. The bench provokes the case on purpose. When a fetch waits on the one line whose contents it changes, it often raises the grant and a write to that line together. The fetched word must be the value from before the write. The next fetch in that block must request a slot again and return the new contents. A call's write to the link register and a `loc_we` to that register in the same cycle are also forced together, and the link value is then checked when the word is fetched and when a return follows.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int PC_W       = 17;
    localparam int WORD_W     = 32;
    localparam int QUAD_WORDS = 4;
    localparam int SEL_W      = $clog2(QUAD_WORDS);
    localparam int QADDR_W    = PC_W - SEL_W;
    localparam int LINE_W     = QUAD_WORDS * WORD_W;
    localparam int LOC_AW     = 9;
    localparam int LOC_DEPTH  = 1 << LOC_AW;

    // first word address served by shared memory
    localparam logic [PC_W-1:0] SPLIT_ADDR = PC_W'(LOC_DEPTH);
    // register that receives the return address and flags
    localparam logic [LOC_AW-1:0] LINK_REG = LOC_AW'('h1EF);

    localparam int LINK_C_BIT = PC_W;
    localparam int LINK_Z_BIT = PC_W + 1;
    localparam int LINK_W     = LINK_Z_BIT + 1;

    typedef enum logic [1:0] {
        BR_JMP     = 2'b00,
        BR_CALL    = 2'b01,
        BR_RET     = 2'b10,
        BR_JMP_ALT = 2'b11
    } br_op_e;

    typedef enum logic {
        FS_FETCH = 1'b0,
        FS_ISSUE = 1'b1
    } fstate_e;

    function automatic logic in_local(input logic [PC_W-1:0] a);
        return a < SPLIT_ADDR;
    endfunction

    function automatic logic [PC_W-1:0] far_target(input logic [LOC_AW-1:0] d,
                                                   input logic [LOC_AW-1:0] s);
        return PC_W'({d, s});
    endfunction

    function automatic logic [WORD_W-1:0] pack_link(input logic [PC_W-1:0] ret,
                                                    input logic z, input logic c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PC_W-1:0] = ret;
        w[LINK_C_BIT] = c;
        w[LINK_Z_BIT] = z;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                    input logic [SEL_W-1:0] s);
        return l[s*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/fetch_regram.sv
module fetch_regram #(
    parameter int AW   = 9,
    parameter int DW   = 32,
    parameter int NARW = 19
) (
    input  logic          clk,
    // priority write port (link register update)
    input  logic          pw_en,
    input  logic [AW-1:0] pw_addr,
    input  logic [DW-1:0] pw_data,
    // ordinary write port
    input  logic          ow_en,
    input  logic [AW-1:0] ow_addr,
    input  logic [DW-1:0] ow_data,
    // full-width read for instruction fetch
    input  logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_data,
    // narrow read for the link register
    input  logic [AW-1:0] n_addr,
    output logic [NARW-1:0] n_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ow_en) mem[ow_addr] <= ow_data;
        // issued last so it wins on an address collision
        if (pw_en) mem[pw_addr] <= pw_data;
    end

    assign f_data = mem[f_addr];
    assign n_data = mem[n_addr][NARW-1:0];
endmodule

// File: rtl/fetch_qlatch.sv
module fetch_qlatch #(
    parameter int TAG_W = 15,
    parameter int DW    = 32,
    parameter int NW    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   fill,
    input  logic [TAG_W-1:0]       fill_tag,
    input  logic [NW*DW-1:0]       fill_line,
    input  logic                   snoop_wr,
    input  logic [TAG_W-1:0]       snoop_tag,
    input  logic [TAG_W-1:0]       look_tag,
    input  logic [$clog2(NW)-1:0]  look_sel,
    output logic                   hit,
    output logic [DW-1:0]          word
);
    localparam int LW = NW * DW;

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic [LW-1:0]    line_q;
    logic [DW-1:0]    words [NW];

    for (genvar k = 0; k < NW; k++) begin : g_split
        assign words[k] = line_q[k*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            valid_q <= 1'b0;
        end else if (fill) begin
            tag_q   <= fill_tag;
            line_q  <= fill_line;
            valid_q <= !(snoop_wr && (snoop_tag == fill_tag));
        end else if (snoop_wr && (snoop_tag == tag_q)) begin
            valid_q <= 1'b0;
        end
    end

    assign hit  = valid_q && (tag_q == look_tag);
    assign word = words[look_sel];
endmodule

// File: rtl/split_fetch.sv
module split_fetch
    import fetch_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 quad_mode,
    input  logic                 slot_grant,
    input  logic [LINE_W-1:0]    rdata,
    output logic                 sh_req,
    output logic [QADDR_W-1:0]   sh_qaddr,
    input  logic                 snoop_wr,
    input  logic [QADDR_W-1:0]   snoop_qaddr,
    input  logic                 loc_we,
    input  logic [LOC_AW-1:0]    loc_waddr,
    input  logic [WORD_W-1:0]    loc_wdata,
    input  logic                 br_valid,
    input  logic [1:0]           br_op,
    input  logic [LOC_AW-1:0]    br_dst,
    input  logic [LOC_AW-1:0]    br_src,
    input  logic                 flag_z,
    input  logic                 flag_c,
    input  logic                 ret_wz,
    input  logic                 ret_wc,
    output logic                 instr_valid,
    output logic [WORD_W-1:0]    instr,
    output logic [PC_W-1:0]      pc,
    output logic                 z_load,
    output logic                 c_load,
    output logic                 z_rest,
    output logic                 c_rest
);
    fstate_e             st;
    logic [PC_W-1:0]     fpc;
    logic [WORD_W-1:0]   instr_q;

    logic                cur_local;
    logic                lat_hit;
    logic                use_latch;
    logic                take_slot;
    logic [WORD_W-1:0]   loc_word;
    logic [WORD_W-1:0]   lat_word;
    logic [WORD_W-1:0]   bus_word;
    logic [LINK_W-1:0]   link_bits;

    logic                issuing;
    logic                br_take;
    br_op_e              op;
    logic [PC_W-1:0]     br_target;
    logic                link_we;
    logic [WORD_W-1:0]   link_word;

    assign cur_local = in_local(fpc);
    assign use_latch = quad_mode && lat_hit && !cur_local;
    assign sh_req    = (st == FS_FETCH) && !cur_local && !use_latch;
    assign sh_qaddr  = fpc[PC_W-1:SEL_W];
    assign take_slot = sh_req && slot_grant;
    assign bus_word  = pick_word(rdata, fpc[SEL_W-1:0]);

    assign issuing   = (st == FS_ISSUE);
    assign br_take   = issuing && br_valid;
    assign op        = br_op_e'(br_op);
    assign link_we   = br_take && (op == BR_CALL);
    assign link_word = pack_link(fpc + PC_W'(1), flag_z, flag_c);

    always_comb begin
        unique case (op)
            BR_RET:  br_target = link_bits[PC_W-1:0];
            default: br_target = far_target(br_dst, br_src);
        endcase
    end

    fetch_regram #(
        .AW   (LOC_AW),
        .DW   (WORD_W),
        .NARW (LINK_W)
    ) u_regram (
        .clk     (clk),
        .pw_en   (link_we),
        .pw_addr (LINK_REG),
        .pw_data (link_word),
        .ow_en   (loc_we),
        .ow_addr (loc_waddr),
        .ow_data (loc_wdata),
        .f_addr  (fpc[LOC_AW-1:0]),
        .f_data  (loc_word),
        .n_addr  (LINK_REG),
        .n_data  (link_bits)
    );

    fetch_qlatch #(
        .TAG_W (QADDR_W),
        .DW    (WORD_W),
        .NW    (QUAD_WORDS)
    ) u_qlatch (
        .clk       (clk),
        .rst       (rst),
        .enable    (quad_mode),
        .fill      (take_slot && quad_mode),
        .fill_tag  (fpc[PC_W-1:SEL_W]),
        .fill_line (rdata),
        .snoop_wr  (snoop_wr),
        .snoop_tag (snoop_qaddr),
        .look_tag  (fpc[PC_W-1:SEL_W]),
        .look_sel  (fpc[SEL_W-1:0]),
        .hit       (lat_hit),
        .word      (lat_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_FETCH;
            fpc     <= RESET_PC;
            instr_q <= '0;
        end else begin
            unique case (st)
                FS_FETCH: begin
                    if (cur_local) begin
                        instr_q <= loc_word;
                        st      <= FS_ISSUE;
                    end else if (use_latch) begin
                        instr_q <= lat_word;
                        st      <= FS_ISSUE;
                    end else if (slot_grant) begin
                        instr_q <= bus_word;
                        st      <= FS_ISSUE;
                    end
                end
                FS_ISSUE: begin
                    fpc <= br_take ? br_target : fpc + PC_W'(1);
                    st  <= FS_FETCH;
                end
                default: st <= FS_FETCH;
            endcase
        end
    end

    assign instr_valid = issuing;
    assign instr       = instr_q;
    assign pc          = fpc;
    assign z_load      = br_take && (op == BR_RET) && ret_wz;
    assign c_load      = br_take && (op == BR_RET) && ret_wc;
    assign z_rest      = link_bits[LINK_Z_BIT];
    assign c_rest      = link_bits[LINK_C_BIT];
endmodule

// File: rtl/split_fetch_props.sv
module split_fetch_props
    import fetch_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                quad_mode,
    input logic                slot_grant,
    input logic                sh_req,
    input logic                br_valid,
    input logic [1:0]          br_op,
    input logic [LOC_AW-1:0]   br_dst,
    input logic [LOC_AW-1:0]   br_src,
    input logic                instr_valid,
    input logic [PC_W-1:0]     pc,
    input logic                z_load,
    input logic                c_load
);
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> !instr_valid);

    a_r2_local_never_requests: assert property (@(posedge clk) disable iff (rst)
        sh_req |-> (pc >= SPLIT_ADDR));

    a_r5_wait_is_idle: assert property (@(posedge clk) disable iff (rst)
        (sh_req && !slot_grant) |=> !instr_valid);

    a_r5_pc_holds: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc));

    a_r6_slot_per_word: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (pc >= SPLIT_ADDR) && !quad_mode && $past(!quad_mode))
            |-> $past(slot_grant));

    a_r4_jump_lands: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && br_valid && (br_op == 2'b00))
            |=> (pc == $past(PC_W'({br_dst[7:0], br_src}))));

    a_r10_flags_only_on_return: assert property (@(posedge clk) disable iff (rst)
        (z_load || c_load) |-> (instr_valid && br_valid && (br_op == 2'b10)));
endmodule

bind split_fetch split_fetch_props u_props (.*);

// File: tb/split_fetch_bench.sv
module split_fetch_bench;
    import fetch_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst, quad_mode, slot_grant, snoop_wr, loc_we, br_valid;
    logic         flag_z, flag_c, ret_wz, ret_wc;
    logic [127:0] rdata;
    logic         sh_req;
    logic [14:0]  sh_qaddr, snoop_qaddr;
    logic [8:0]   loc_waddr, br_dst, br_src;
    logic [31:0]  loc_wdata, instr;
    logic [1:0]   br_op;
    logic         instr_valid;
    logic [16:0]  pc;
    logic         z_load, c_load, z_rest, c_rest;

    split_fetch u_split_fetch (.*);

    int checks = 0;
    int errors = 0;

    localparam logic [14:0] HOT_Q = 15'h081;
    int unsigned epoch = 0;

    function automatic logic [31:0] shw(input logic [16:0] a, input int unsigned ep);
        logic [31:0] v;
        v = (32'(a) * 32'h9E3779B1) ^ 32'hC0DE0000;
        if (a[16:2] == HOT_Q) v = v + ep;
        return v;
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++) rdata[k*32 +: 32] = shw({sh_qaddr, 2'(k)}, epoch);
    end

    function automatic logic [16:0] pick_target();
        case ($urandom % 7)
            0:       return 17'($urandom % 512);
            1:       return 17'h1FC + 17'($urandom % 4);
            2:       return 17'h200 + 17'($urandom % 64);
            3:       return 17'h204 + 17'($urandom % 4);
            4:       return 17'($urandom);
            5:       return 17'h1FFFC + 17'($urandom % 4);
            default: return 17'h1EC + 17'($urandom % 4);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference state
    logic [31:0] lmem [512];
    bit          m_valid = 0;
    logic [14:0] m_tag = '0;
    logic [31:0] m_line [4];
    string       m_why = "R7";
    logic [16:0] e_pc;
    bit          e_issue;
    logic [31:0] e_instr;
    string       e_tag, pc_tag;
    bit          pend_hot = 0;
    int          n_iss = 0, coinc = 0, hits = 0;

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        rst = 1; quad_mode = 1; slot_grant = 0; snoop_wr = 0; snoop_qaddr = '0;
        loc_we = 0; loc_waddr = '0; loc_wdata = '0; br_valid = 0; br_op = '0;
        br_dst = '0; br_src = '0; flag_z = 0; flag_c = 0; ret_wz = 0; ret_wc = 0;
        repeat (2) @(negedge clk);
        for (int a = 0; a < 512; a++) begin
            loc_we = 1; loc_waddr = 9'(a); loc_wdata = $urandom; lmem[a] = loc_wdata;
            @(negedge clk);
        end
        loc_we = 0;
        rst = 0;
        #1;
        chk(instr_valid == 1'b0, "R1", "instr_valid", instr_valid, 0);
        chk(pc == 17'h0, "R1", "pc", pc, 0);
        chk(sh_req == 1'b0, "R1", "sh_req", sh_req, 0);
        e_pc = '0; e_issue = 0; e_instr = '0; e_tag = "R1"; pc_tag = "R1";

        for (int cyc = 0; cyc < 8000; cyc++) begin
            bit          now_issue, hit, exp_req, fill;
            int          op, r;
            logic [16:0] t, nxt;
            logic [31:0] lk;

            // outputs registered at the last edge
            chk(instr_valid === e_issue, e_tag, "instr_valid", instr_valid, e_issue);
            if (e_issue) begin
                chk(pc === e_pc, pc_tag, "pc", pc, e_pc);
                chk(instr === e_instr, e_tag, "instr", instr, e_instr);
            end else begin
                chk(pc === e_pc, "R5", "pc hold", pc, e_pc);
            end
            if (pend_hot) begin epoch++; pend_hot = 0; end

            now_issue = e_issue;
            br_valid = 0; loc_we = 0; snoop_wr = 0; slot_grant = 0; ret_wz = 0; ret_wc = 0;
            br_op = '0; br_dst = '0; br_src = '0;
            flag_z = 1'($urandom); flag_c = 1'($urandom);
            if ($urandom % 64 == 0) quad_mode = ~quad_mode;
            hit = quad_mode && m_valid && (m_tag == e_pc[16:2]) && (e_pc >= 17'h200);
            op = 0; t = '0; nxt = e_pc + 17'd1; fill = 0; exp_req = 0;

            if (now_issue) begin
                r = $urandom % 8;
                case (n_iss)
                    0:       begin op = 1; t = 17'h1FE; end
                    1, 2, 3: op = 0;
                    4:       begin op = 2; t = 17'h205; end
                    5:       op = 3;
                    default: begin op = (r < 3) ? r + 1 : 0; t = pick_target(); end
                endcase
                slot_grant = 1'($urandom);
                if (op == 1 || op == 2) begin
                    br_valid = 1;
                    br_op = (op == 2) ? 2'b01 : (($urandom % 2) ? 2'b11 : 2'b00);
                    br_dst = {1'($urandom), t[16:9]};
                    br_src = t[8:0];
                    nxt = t;
                    if (op == 2 && ($urandom % 2)) begin
                        loc_we = 1; loc_waddr = LINK_REG; loc_wdata = $urandom;
                    end
                end else if (op == 3) begin
                    br_valid = 1; br_op = 2'b10;
                    ret_wz = 1'($urandom); ret_wc = 1'($urandom);
                    br_dst = 9'($urandom); br_src = 9'($urandom);
                    lk = lmem[LINK_REG];
                    nxt = lk[16:0];
                end
                if (!loc_we && $urandom % 16 == 0) begin
                    loc_we = 1; loc_waddr = 9'($urandom); loc_wdata = $urandom;
                end
            end else begin
                if (!hit && e_pc >= 17'h200 && e_pc[16:2] == HOT_Q && ($urandom % 2)) begin
                    slot_grant = 1; snoop_wr = 1; snoop_qaddr = HOT_Q;
                end else begin
                    slot_grant = ($urandom % 3 == 0);
                end
                if (!snoop_wr && $urandom % 16 == 0) begin
                    snoop_wr = 1;
                    case ($urandom % 4)
                        0:       snoop_qaddr = HOT_Q;
                        1:       snoop_qaddr = e_pc[16:2];
                        2:       snoop_qaddr = m_tag;
                        default: snoop_qaddr = 15'($urandom);
                    endcase
                end
                if ($urandom % 8 == 0) begin
                    br_valid = 1; br_op = 2'b00;
                    br_dst = 9'($urandom); br_src = 9'($urandom);
                end
                if ($urandom % 16 == 0) begin
                    loc_we = 1; loc_waddr = 9'($urandom); loc_wdata = $urandom;
                end
            end
            if (snoop_wr && snoop_qaddr == HOT_Q) pend_hot = 1;

            #1;
            if (now_issue) begin
                if (op == 3) begin
                    chk(z_load == ret_wz, "R10", "z_load", z_load, ret_wz);
                    chk(c_load == ret_wc, "R10", "c_load", c_load, ret_wc);
                    chk(z_rest == lk[18], "R10", "z_rest", z_rest, lk[18]);
                    chk(c_rest == lk[17], "R10", "c_rest", c_rest, lk[17]);
                end else begin
                    chk(!z_load && !c_load, "R10", "flag loads", {z_load, c_load}, 0);
                end
                chk(sh_req == 1'b0, "R3", "sh_req in issue", sh_req, 0);
                pc_tag = (op == 2) ? "R9" : (op == 3) ? "R10" : "R4";
                e_tag = "R3";
                e_issue = 0;
            end else begin
                if (e_pc < 17'h200) begin
                    e_instr = lmem[e_pc[8:0]];
                    e_issue = 1;
                    e_tag = (e_pc[8:0] == LINK_REG) ? "R9" : "R2";
                end else if (hit) begin
                    e_instr = m_line[e_pc[1:0]];
                    e_issue = 1;
                    e_tag = "R7";
                    hits++;
                end else begin
                    exp_req = 1;
                    if (slot_grant) begin
                        e_instr = shw(e_pc, epoch);
                        e_issue = 1;
                        e_tag = quad_mode ? "R7" : "R6";
                    end else begin
                        e_issue = 0;
                        e_tag = "R5";
                    end
                    if (m_tag == e_pc[16:2] && !m_valid) e_tag = m_why;
                    fill = slot_grant && quad_mode;
                end
                chk(sh_req == exp_req, e_tag, "sh_req", sh_req, exp_req);
                if (exp_req)
                    chk(sh_qaddr == e_pc[16:2], "R2", "sh_qaddr", sh_qaddr, e_pc[16:2]);
                chk(!z_load && !c_load, "R10", "flag loads", {z_load, c_load}, 0);
                pc_tag = "R4";
            end

            // latch reference update
            if (!quad_mode) begin
                m_valid = 0; m_why = "R11";
            end else if (fill) begin
                m_tag = e_pc[16:2];
                for (int k = 0; k < 4; k++) m_line[k] = shw({m_tag, 2'(k)}, epoch);
                m_valid = !(snoop_wr && snoop_qaddr == m_tag);
                m_why = m_valid ? "R7" : "R8";
                if (!m_valid) coinc++;
            end else if (snoop_wr && snoop_qaddr == m_tag && m_valid) begin
                m_valid = 0; m_why = "R8";
            end

            if (loc_we) lmem[loc_waddr] = loc_wdata;
            if (now_issue) begin
                if (op == 2) lmem[LINK_REG] = {13'b0, flag_z, flag_c, e_pc + 17'd1};
                e_pc = nxt;
                n_iss++;
            end

            @(negedge clk);
        end

        chk(coinc > 0, "R8", "same-cycle fill and snoop seen", coinc, 1);
        chk(hits > 0, "R7", "latch hits seen", hits, 1);
        chk(n_iss > 500, "R3", "instructions issued", n_iss, 500);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule